// File: doc/BRIEF.md
# Token-Headed Packet Receiver

This block sits behind a byte-wide serial receive path, for example the received-byte strobe of a serial peripheral slave, and turns the raw byte stream into packets. Each packet opens with a single header byte. The upper bits of the header carry a packet type code and the lower bits carry the number of payload bytes that follow. Between packets the sender fills the line with a reserved idle byte, and the parser drops it. Two header values are rejected as malformed: all-zero, and all-ones, which is what a disconnected line with a pull-up returns. Any header whose type field is zero is also rejected.

Once a header is accepted, the next N bytes are payload whatever their value. A payload byte is never mistaken for an idle byte or a header. The payload leaves the block as a beat stream with start and end markers. A header with a zero length is a legal request-only packet, and it produces start and end in the same cycle. A frame-abort input, for example a slave select that goes inactive, forces the parser back to waiting for a header. If payload bytes were still owed, the block reports a truncated packet.

All outputs are registered and respond one clock after the byte or abort that causes them. Header and truncation errors are single-cycle pulses.

Top module: `hdr_pkt_parser`

## Requirements
- R1: A valid header sets pktType to its upper field (bits 7:4) and pktLen to its lower field (bits 3:0, range 0 to 15), and pulses startOut one cycle after the header byte.
- R2: A header is valid only if its type field is non-zero and it is not 0xFF, so any byte from 0x00 to 0x0F, or 0xFF, is not a valid header.
- R3: An invalid header byte received while waiting for a header gives a one-cycle hdrErr pulse, is dropped, and leaves the parser waiting for a header.
- R4: The idle byte 0x55 received while waiting for a header produces no output of any kind and leaves the parser waiting for a header.
- R5: After a header of length N, the next N valid bytes appear in order on beatData with beatValid, whatever their value, including 0x55, 0x00, 0xFF and header-like values.
- R6: A header with length 0 pulses startOut and endOut in the same cycle and produces no payload beat.
- R7: endOut is asserted in the same cycle as the last payload beat, and the byte after that beat is treated as a header.
- R8: An abort while payload bytes are still owed gives a one-cycle truncErr pulse one clock later, and the parser returns to waiting for a header.
- R9: An abort while waiting for a header raises no error. A byte presented in the same cycle as an abort is ignored.
- R10: Cycles with byteValid low change nothing, so gaps are allowed within a payload.
- R11: After reset all pulse outputs are low, pktType and pktLen are zero, and the parser waits for a header.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| byteValid | input | 1 | A received byte is present on byteData |
| byteData | input | 8 | Received byte |
| abortIn | input | 1 | Frame abort; returns the parser to waiting for a header |
| pktType | output | 4 | Type field of the last accepted header |
| pktLen | output | 4 | Length field of the last accepted header |
| startOut | output | 1 | Pulse when a header is accepted |
| endOut | output | 1 | Pulse on the last payload beat, or together with startOut for length 0 |
| beatValid | output | 1 | Payload beat present on beatData |
| beatData | output | 8 | Payload byte |
| hdrErr | output | 1 | Pulse for an invalid header byte |
| truncErr | output | 1 | Pulse for a packet cut short by abort |

## Verification
The bench builds the block with its default parameters: 8-bit bytes, a 4-bit length field and 0x55 as the idle code. With those values the longest packet, fifteen payload bytes, is short enough to drive in full, and every reserved value can be fed in directly. That lets the bench mix idle, all-zero, all-ones and header-like bytes into payloads, and test an abort in each parser state, including an abort that arrives together with a byte.

// File: rtl/hpp_pkg.sv
`timescale 1ns/1ps
package hpp_pkg;

  // Strobes from control to datapath, one per registered action.
  typedef struct packed {
    logic loadHdr;
    logic passBeat;
    logic markStart;
    logic markEnd;
    logic flagHdr;
    logic flagTrunc;
  } ctlStrobe_t;

  typedef enum logic {
    S_WAIT = 1'b0,
    S_BODY = 1'b1
  } parseState_t;

endpackage

// File: rtl/hpp_ctrl.sv
`timescale 1ns/1ps
module hpp_ctrl
  import hpp_pkg::*;
#(
  parameter int LEN_W = 4
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             byteValid,
  input  logic             abortIn,
  input  logic             hdrIdle,
  input  logic             hdrBad,
  input  logic [LEN_W-1:0] hdrLen,
  output ctlStrobe_t       strb,
  output logic             inWait
);

  parseState_t      state, nextState;
  logic [LEN_W-1:0] remaining, nextRem;

  always_comb begin
    strb      = '0;
    nextState = state;
    nextRem   = remaining;
    if (abortIn) begin
      strb.flagTrunc = (state == S_BODY);
      nextState      = S_WAIT;
      nextRem        = '0;
    end else if (byteValid) begin
      if (state == S_WAIT) begin
        if (hdrIdle) begin
          nextState = S_WAIT;
        end else if (hdrBad) begin
          strb.flagHdr = 1'b1;
        end else begin
          strb.loadHdr   = 1'b1;
          strb.markStart = 1'b1;
          if (hdrLen == '0) begin
            strb.markEnd = 1'b1;
          end else begin
            nextState = S_BODY;
            nextRem   = hdrLen;
          end
        end
      end else begin
        strb.passBeat = 1'b1;
        nextRem       = remaining - 1'b1;
        if (remaining == LEN_W'(1)) begin
          strb.markEnd = 1'b1;
          nextState    = S_WAIT;
        end
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      state     <= S_WAIT;
      remaining <= '0;
    end else begin
      state     <= nextState;
      remaining <= nextRem;
    end
  end

  assign inWait = (state == S_WAIT);

  // While inside a payload there is always at least one byte still owed.
  p_body_owes_r7: assert property (@(posedge clk) disable iff (!rstN)
    (state == S_BODY) |-> (remaining != '0));

  // Leaving the payload state without an abort must mark the packet end.
  p_exit_marks_end_r7: assert property (@(posedge clk) disable iff (!rstN)
    (state == S_BODY && !abortIn && byteValid && remaining == LEN_W'(1)) |=> (state == S_WAIT));

endmodule

// File: rtl/hpp_datapath.sv
`timescale 1ns/1ps
module hpp_datapath
  import hpp_pkg::*;
#(
  parameter int              DATA_W    = 8,
  parameter int              LEN_W     = 4,
  parameter logic [DATA_W-1:0] IDLE_CODE = 8'h55
) (
  input  logic                    clk,
  input  logic                    rstN,
  input  logic [DATA_W-1:0]       byteData,
  input  ctlStrobe_t              strb,
  output logic                    hdrIdle,
  output logic                    hdrBad,
  output logic [LEN_W-1:0]        hdrLen,
  output logic [DATA_W-LEN_W-1:0] pktType,
  output logic [LEN_W-1:0]        pktLen,
  output logic                    startOut,
  output logic                    endOut,
  output logic                    beatValid,
  output logic [DATA_W-1:0]       beatData,
  output logic                    hdrErr,
  output logic                    truncErr
);

  localparam int TYPE_W = DATA_W - LEN_W;

  logic [TYPE_W-1:0] hdrType;

  assign hdrType = byteData[DATA_W-1:LEN_W];
  assign hdrLen  = byteData[LEN_W-1:0];
  assign hdrIdle = (byteData == IDLE_CODE);
  assign hdrBad  = (hdrType == '0) || (&byteData);

  always_ff @(posedge clk) begin
    if (!rstN) begin
      pktType   <= '0;
      pktLen    <= '0;
      startOut  <= 1'b0;
      endOut    <= 1'b0;
      beatValid <= 1'b0;
      beatData  <= '0;
      hdrErr    <= 1'b0;
      truncErr  <= 1'b0;
    end else begin
      startOut  <= strb.markStart;
      endOut    <= strb.markEnd;
      beatValid <= strb.passBeat;
      hdrErr    <= strb.flagHdr;
      truncErr  <= strb.flagTrunc;
      if (strb.loadHdr) begin
        pktType <= hdrType;
        pktLen  <= hdrLen;
      end
      if (strb.passBeat) begin
        beatData <= byteData;
      end
    end
  end

  // Header fields only change when a header is accepted.
  p_fields_stable_r1: assert property (@(posedge clk) disable iff (!rstN)
    !startOut |-> ($stable(pktType) || $past(!rstN)) || $past(strb.loadHdr));

  // Exactly one of start, header error, truncation per cycle at most.
  p_event_excl_r3: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0({startOut, hdrErr, truncErr}));

endmodule

// File: rtl/hdr_pkt_parser.sv
`timescale 1ns/1ps
module hdr_pkt_parser
  import hpp_pkg::*;
#(
  parameter int                DATA_W    = 8,
  parameter int                LEN_W     = 4,
  parameter logic [DATA_W-1:0] IDLE_CODE = 8'h55
) (
  input  logic                    clk,
  input  logic                    rstN,
  input  logic                    byteValid,
  input  logic [DATA_W-1:0]       byteData,
  input  logic                    abortIn,
  output logic [DATA_W-LEN_W-1:0] pktType,
  output logic [LEN_W-1:0]        pktLen,
  output logic                    startOut,
  output logic                    endOut,
  output logic                    beatValid,
  output logic [DATA_W-1:0]       beatData,
  output logic                    hdrErr,
  output logic                    truncErr
);

  ctlStrobe_t       strb;
  logic             hdrIdle;
  logic             hdrBad;
  logic [LEN_W-1:0] hdrLen;
  logic             inWait;

  hpp_ctrl #(.LEN_W(LEN_W)) i_ctrl (
    .clk       (clk),
    .rstN      (rstN),
    .byteValid (byteValid),
    .abortIn   (abortIn),
    .hdrIdle   (hdrIdle),
    .hdrBad    (hdrBad),
    .hdrLen    (hdrLen),
    .strb      (strb),
    .inWait    (inWait)
  );

  hpp_datapath #(.DATA_W(DATA_W), .LEN_W(LEN_W), .IDLE_CODE(IDLE_CODE)) i_datapath (
    .clk       (clk),
    .rstN      (rstN),
    .byteData  (byteData),
    .strb      (strb),
    .hdrIdle   (hdrIdle),
    .hdrBad    (hdrBad),
    .hdrLen    (hdrLen),
    .pktType   (pktType),
    .pktLen    (pktLen),
    .startOut  (startOut),
    .endOut    (endOut),
    .beatValid (beatValid),
    .beatData  (beatData),
    .hdrErr    (hdrErr),
    .truncErr  (truncErr)
  );

  p_idle_dropped_r4: assert property (@(posedge clk) disable iff (!rstN)
    (byteValid && !abortIn && inWait && byteData == IDLE_CODE)
      |=> (!startOut && !hdrErr && !beatValid));

  p_bad_header_r3: assert property (@(posedge clk) disable iff (!rstN)
    (byteValid && !abortIn && inWait && byteData != IDLE_CODE &&
     (byteData[DATA_W-1:LEN_W] == '0 || &byteData)) |=> (hdrErr && !startOut));

  p_zero_len_r6: assert property (@(posedge clk) disable iff (!rstN)
    (startOut && pktLen == '0) |-> (endOut && !beatValid));

  p_trunc_cause_r8: assert property (@(posedge clk) disable iff (!rstN)
    truncErr |-> $past(abortIn));

  p_abort_quiet_r9: assert property (@(posedge clk) disable iff (!rstN)
    abortIn |=> (!startOut && !beatValid && !hdrErr && !endOut));

  p_beat_source_r10: assert property (@(posedge clk) disable iff (!rstN)
    beatValid |-> $past(byteValid));

endmodule

// File: tb/test_hdr_pkt_parser.sv
`timescale 1ns/1ps
module test_hdr_pkt_parser;

  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic       byteValid = 1'b0;
  logic [7:0] byteData = 8'h00;
  logic       abortIn = 1'b0;
  logic [3:0] pktType;
  logic [3:0] pktLen;
  logic       startOut, endOut, beatValid, hdrErr, truncErr;
  logic [7:0] beatData;

  always #2.5 clk = ~clk;

  hdr_pkt_parser i_hdr_pkt_parser (
    .clk(clk), .rstN(rstN), .byteValid(byteValid), .byteData(byteData),
    .abortIn(abortIn), .pktType(pktType), .pktLen(pktLen),
    .startOut(startOut), .endOut(endOut), .beatValid(beatValid),
    .beatData(beatData), .hdrErr(hdrErr), .truncErr(truncErr)
  );

  typedef struct {
    bit st; bit en; bit bv; bit he; bit te;
    logic [7:0] d; logic [3:0] ty; logic [3:0] ln;
    string req;
  } exp_t;

  exp_t q[$];
  int   checks = 0;
  int   fails  = 0;
  bit   mWait  = 1'b1;
  int   mRem   = 0;
  bit   done   = 1'b0;

  // Reference model, written from the requirements.
  task automatic sendByte(input logic [7:0] b, input bit ab = 1'b0, input bit v = 1'b1);
    exp_t e;
    bit   has = 1'b0;
    e = '{st:0, en:0, bv:0, he:0, te:0, d:8'h00, ty:4'h0, ln:4'h0, req:""};
    if (ab) begin
      if (!mWait) begin e.te = 1'b1; e.req = "R8"; has = 1'b1; end
      mWait = 1'b1; mRem = 0;
    end else if (v) begin
      if (mWait) begin
        if (b == 8'h55) begin
          has = 1'b0;
        end else if (b[7:4] == 4'h0 || b == 8'hFF) begin
          e.he = 1'b1; e.req = "R2/R3"; has = 1'b1;
        end else begin
          e.st = 1'b1; e.ty = b[7:4]; e.ln = b[3:0]; has = 1'b1; e.req = "R1";
          if (b[3:0] == 4'h0) begin e.en = 1'b1; e.req = "R6"; end
          else begin mWait = 1'b0; mRem = int'(b[3:0]); end
        end
      end else begin
        e.bv = 1'b1; e.d = b; has = 1'b1; e.req = "R5";
        if (mRem == 1) begin e.en = 1'b1; e.req = "R7"; mWait = 1'b1; end
        mRem--;
      end
    end
    if (has) q.push_back(e);
    @(negedge clk);
    byteValid = v; byteData = b; abortIn = ab;
  endtask

  task automatic gap(input int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      byteValid = 1'b0; abortIn = 1'b0; byteData = 8'hA5;
    end
  endtask

  task automatic check(input bit ok, input string req, input string what);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: %s", req, what);
    end
  endtask

  // Monitor: compare every output event against the scoreboard.
  always @(posedge clk) begin
    #1;
    if (rstN && !done && (startOut || endOut || beatValid || hdrErr || truncErr)) begin
      if (q.size() == 0) begin
        check(1'b0, "R4/R9/R10", $sformatf("unexpected event st=%0b en=%0b bv=%0b he=%0b te=%0b, expected none",
              startOut, endOut, beatValid, hdrErr, truncErr));
      end else begin
        exp_t e;
        bit   bad;
        e = q.pop_front();
        bad = (e.st != startOut) || (e.en != endOut) || (e.bv != beatValid) ||
              (e.he != hdrErr) || (e.te != truncErr) ||
              (e.bv && beatData != e.d) ||
              (e.st && (pktType != e.ty || pktLen != e.ln));
        check(!bad, e.req, $sformatf(
          "got st=%0b en=%0b bv=%0b d=%h he=%0b te=%0b ty=%h ln=%h, expected st=%0b en=%0b bv=%0b d=%h he=%0b te=%0b ty=%h ln=%h",
          startOut, endOut, beatValid, beatData, hdrErr, truncErr, pktType, pktLen,
          e.st, e.en, e.bv, e.d, e.he, e.te, e.ty, e.ln));
      end
    end
  end

  task automatic finishRun();
    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  endtask

  initial begin
    #(200000.0);
    check(1'b0, "watchdog", "run did not complete, expected completion");
    finishRun();
  end

  initial begin
    repeat (4) @(negedge clk);
    // R11: reset state
    check(!startOut && !endOut && !beatValid && !hdrErr && !truncErr, "R11",
          $sformatf("pulses=%b expected 00000", {startOut, endOut, beatValid, hdrErr, truncErr}));
    check(pktType == 4'h0 && pktLen == 4'h0, "R11",
          $sformatf("type=%h len=%h expected 0 0", pktType, pktLen));
    rstN = 1'b1;
    gap(2);

    // R4: idle bytes dropped, then R1/R5/R7 packet with reserved values inside
    sendByte(8'h55); sendByte(8'h55);
    sendByte(8'h13);
    sendByte(8'h55); sendByte(8'hFF); sendByte(8'h00);
    sendByte(8'h24);  // header-like byte after end: R7 treats as header
    sendByte(8'h21); sendByte(8'h3F); sendByte(8'h12); sendByte(8'h9C);
    gap(2);

    // R6: zero-length request packet, back to back
    sendByte(8'h70); sendByte(8'hA0);
    gap(1);

    // R2/R3: invalid headers, then a valid one proves still waiting
    sendByte(8'h00); sendByte(8'hFF); sendByte(8'h07); sendByte(8'h0F);
    sendByte(8'h11); sendByte(8'h00);
    gap(2);

    // R10: gaps inside a payload
    sendByte(8'hC3);
    sendByte(8'h01); gap(3);
    sendByte(8'h02); gap(1);
    sendByte(8'h03);
    sendByte(8'h42, 1'b0, 1'b0);  // byteValid low: ignored
    gap(2);

    // R8: abort mid-payload, then recovery
    sendByte(8'h34); sendByte(8'hAA); sendByte(8'hBB);
    sendByte(8'h00, 1'b1);
    sendByte(8'h55);              // idle again after abort
    sendByte(8'h51); sendByte(8'hEE);
    gap(2);

    // R9: abort while waiting, and abort with a same-cycle header byte
    sendByte(8'h00, 1'b1);
    sendByte(8'h62, 1'b1);
    gap(1);
    sendByte(8'h82); sendByte(8'h10); sendByte(8'h20);
    gap(2);

    // R1/R5: longest packet, payload filled with reserved and header values
    sendByte(8'hEF);
    for (int i = 0; i < 15; i++) begin
      case (i % 4)
        0: sendByte(8'h55);
        1: sendByte(8'hFF);
        2: sendByte(8'h00);
        default: sendByte(8'h1F + 8'(i));
      endcase
    end
    sendByte(8'hF2); sendByte(8'h5A); sendByte(8'hA5);
    gap(4);

    check(q.size() == 0, "R5/R7", $sformatf("%0d expected events never seen, expected 0", q.size()));
    finishRun();
  end

endmodule